// File: doc/BRIEF.md
# Shared Buffer Ownership Arbiter

This block decides which of three agents may use a single shared data buffer: a host processor, a USB engine and a transfer coprocessor. Each agent raises a request line and waits for its grant. The block also returns a registered two-bit owner code that steers the buffer's data-path multiplexer.

Ownership is non-preemptive and has no time limit. Once an agent holds the buffer, it keeps it for as long as its request stays high. Requests from the other agents go unanswered during that time, even when they have higher priority. When the owner lowers its request, the buffer becomes free for one cycle. In that free cycle a fixed chain picks the next owner: the processor first, then USB, then the coprocessor.

Top module: `buf_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the owner code to 0 (free) and lowers every grant on the following clock edge.
- R2: The owner code maps to the grants as follows: 0 = no grant, 1 = processor grant, 2 = USB grant, 3 = coprocessor grant. At most one grant is high at any time.
- R3: When the buffer is free and at least one request is high at a clock edge, that edge grants the highest-priority requester. The order is processor, then USB, then coprocessor.
- R4: An owner whose request is still high at a clock edge keeps its grant across that edge. There is no limit on how long it holds, and requests from other agents, including higher-priority ones, do not take the grant away.
- R5: When the owner's request is low at a clock edge, that edge lowers all grants and sets the owner code to 0.
- R6: When the buffer is free and no request is high at a clock edge, the buffer stays free.
- R7: A request that is pending when the owner releases is not granted at the releasing edge. It competes, together with any request raised in the free cycle, at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cpu | input | 1 | Host processor request |
| req_usb | input | 1 | USB engine request |
| req_cop | input | 1 | Transfer coprocessor request |
| gnt_cpu | output | 1 | Host processor grant |
| gnt_usb | output | 1 | USB engine grant |
| gnt_cop | output | 1 | Transfer coprocessor grant |
| owner | output | 2 | Registered owner code for the buffer multiplexer (0 free, 1 processor, 2 USB, 3 coprocessor) |

## Verification
The owner code and the grants respond one rising edge after the requests they depend on. After a release, the next owner appears two edges after the request drops, because the free cycle lies in between. The bench applies request changes at falling edges. At each falling edge it first advances its own ownership model by one edge, using the request values that were stable across the edge just passed. It then compares the ports with that model before it applies the next stimulus. Each comparison is tagged with the requirement that matches the situation: reset, free with requests, free and idle, holding, releasing, or releasing with others waiting.

// File: rtl/buf_arbiter.sv
module buf_arbiter (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_cpu,
  input  logic       req_usb,
  input  logic       req_cop,
  output logic       gnt_cpu,
  output logic       gnt_usb,
  output logic       gnt_cop,
  output logic [1:0] owner
);
  localparam logic [1:0] OWN_FREE = 2'd0;
  localparam logic [1:0] OWN_CPU  = 2'd1;
  localparam logic [1:0] OWN_USB  = 2'd2;
  localparam logic [1:0] OWN_COP  = 2'd3;

  logic [1:0] owner_q, owner_d;
  logic       still_held;

  always_comb begin
    case (owner_q)
      OWN_CPU: still_held = req_cpu;
      OWN_USB: still_held = req_usb;
      OWN_COP: still_held = req_cop;
      default: still_held = 1'b0;
    endcase
  end

  always_comb begin
    owner_d = owner_q;
    if (owner_q == OWN_FREE) begin
      if (req_cpu)      owner_d = OWN_CPU;
      else if (req_usb) owner_d = OWN_USB;
      else if (req_cop) owner_d = OWN_COP;
    end else if (!still_held) begin
      owner_d = OWN_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_FREE;
    else     owner_q <= owner_d;
  end

  assign owner   = owner_q;
  assign gnt_cpu = (owner_q == OWN_CPU);
  assign gnt_usb = (owner_q == OWN_USB);
  assign gnt_cop = (owner_q == OWN_COP);
endmodule

module buf_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_cpu,
  input logic       req_usb,
  input logic       req_cop,
  input logic       gnt_cpu,
  input logic       gnt_usb,
  input logic       gnt_cop,
  input logic [1:0] owner
);
  logic any_gnt;
  assign any_gnt = gnt_cpu | gnt_usb | gnt_cop;

  assert_reset_free_R1: assert property (@(posedge clk)
    rst |=> (owner == 2'd0 && !any_gnt));

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_cpu, gnt_usb, gnt_cop}));

  assert_pick_cpu_R3: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && req_cpu) |=> gnt_cpu);
  assert_pick_usb_R3: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && !req_cpu && req_usb) |=> gnt_usb);
  assert_pick_cop_R3: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && !req_cpu && !req_usb && req_cop) |=> gnt_cop);

  assert_hold_cpu_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt_cpu && req_cpu) |=> gnt_cpu);
  assert_hold_usb_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt_usb && req_usb) |=> gnt_usb);
  assert_hold_cop_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt_cop && req_cop) |=> gnt_cop);

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    ((gnt_cpu && !req_cpu) || (gnt_usb && !req_usb) || (gnt_cop && !req_cop))
      |=> (!any_gnt && owner == 2'd0));

  assert_stay_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && !req_cpu && !req_usb && !req_cop) |=> !any_gnt);
endmodule

bind buf_arbiter buf_arbiter_chk u_chk (
  .clk(clk), .rst(rst),
  .req_cpu(req_cpu), .req_usb(req_usb), .req_cop(req_cop),
  .gnt_cpu(gnt_cpu), .gnt_usb(gnt_usb), .gnt_cop(gnt_cop),
  .owner(owner)
);

// File: tb/tb_buf_arbiter.sv
module tb_buf_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] r   = 3'b000;
  logic       gc, gu, gp;
  logic [1:0] own;
  int         checks = 0;
  int         fails  = 0;
  logic [1:0] exp_own = 2'd0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  buf_arbiter dut (
    .clk(clk), .rst(rst),
    .req_cpu(r[0]), .req_usb(r[1]), .req_cop(r[2]),
    .gnt_cpu(gc), .gnt_usb(gu), .gnt_cop(gp),
    .owner(own)
  );

  function automatic logic [1:0] model_next(logic [1:0] o, logic [2:0] q);
    if (o == 2'd0) return q[0] ? 2'd1 : q[1] ? 2'd2 : q[2] ? 2'd3 : 2'd0;
    return q[o - 2'd1] ? o : 2'd0;
  endfunction

  function automatic logic [2:0] decode(logic [1:0] o);
    return (o == 2'd0) ? 3'b000 : (3'b001 << (o - 2'd1));
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(logic [2:0] nr);
    logic [1:0] prev;
    logic [2:0] q;
    string tag;
    prev = exp_own;
    q = r;
    @(negedge clk);
    exp_own = rst ? 2'd0 : model_next(prev, q);
    if (rst) tag = "R1";
    else if (prev == 2'd0) tag = (q != 3'b000) ? "R3" : "R6";
    else if (q[prev - 2'd1]) tag = "R4";
    else if ((q & ~(3'b001 << (prev - 2'd1))) != 3'b000) tag = "R7";
    else tag = "R5";
    chk(own == exp_own, tag, own, exp_own);
    chk({gp, gu, gc} == decode(exp_own), "R2", {gp, gu, gc}, decode(exp_own));
    r = nr;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    step(3'b000);
    step(3'b000);
    rst = 1'b0;
    step(3'b000);                       // R6 idle
    step(3'b111);
    step(3'b111);                       // R3 all three: CPU wins
    step(3'b111); step(3'b111);         // R4 holding
    step(3'b110);                       // CPU drops, others waiting
    step(3'b110);                       // R7 release edge -> free
    step(3'b110);                       // R3 USB wins
    step(3'b100);                       // USB drops
    step(3'b101);                       // R7 free; CPU raised in free cycle
    step(3'b101);                       // R3 CPU beats coprocessor
    step(3'b100);
    step(3'b100);
    step(3'b100);                       // coprocessor granted
    step(3'b111);                       // higher priority arrives
    for (int i = 0; i < 20; i++) step(3'b111); // R4 no preemption, long hold
    step(3'b000);                       // R5 release with nothing pending
    step(3'b000);
    step(3'b000);
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] flip;
      for (int b = 0; b < 3; b++) flip[b] = ($urandom % 4) == 0;
      step(r ^ flip);
    end
    rst = 1'b1;
    step(3'b111);
    step(3'b111);                       // R1 reset mid-traffic
    rst = 1'b0;
    step(3'b000);
    step(3'b000);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule